// File: doc/BRIEF.md
# DMA Engine Control and Status Register Bank

This block is the software-facing register bank of a simple block-transfer DMA engine. A host reaches it over a 32-bit pipelined Wishbone-style register bus and uses it for three things. It programs the transfer parameters: a 64-bit host start address, a byte count, a 64-bit next-descriptor pointer and an attribute word. It launches or cancels a transfer through a control word. It reads the engine's progress back from a status word. The bank turns control writes into single-cycle start and abort pulses for the transfer engine. It holds the byte-swap mode as a level, and it follows the engine's done, error and aborted indications.

Engine progress is tracked by a four-state machine. The state is visible in status bits [1:0]: IDLE = 00, BUSY = 01, FAULT = 10, ABORTED = 11. There are four named transitions. GO takes IDLE, FAULT or ABORTED to BUSY on a start request. FINISH takes BUSY to IDLE on the engine's done input. TRIP takes BUSY to FAULT on the error input. CANCEL takes BUSY to ABORTED on an abort request or on the engine's aborted input. FINISH also sets a sticky done flag in status bit 2, and that flag drives the level interrupt. Software clears the flag by writing 1 to bit 2 of the status word.

Word offsets (byte addresses): control 0x00, status 0x04, host address low 0x0C, host address high 0x10, byte count 0x14, next pointer low 0x18, next pointer high 0x1C, attribute 0x20.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset every register reads zero, irq_o is low, eng_start_o and eng_abort_o are low, and eng_swap_o is 00.
- R2: Every bus cycle with cyc and stb high gets an ack in the following cycle. For a read, the data appears alongside that ack. A read of an unmapped offset, including 0x08, offsets above 0x20 and any address with bits [1:0] not 00, returns zero. A write to such an address changes no register.
- R3: The registers at 0x0C, 0x10, 0x14, 0x18, 0x1C and 0x20 read back the full 32-bit value last written. They drive host_addr_o ({0x10, 0x0C}), xfer_bytes_o, next_desc_o ({0x1C, 0x18}) and xfer_attr_o.
- R4: A control write with bit 0 set and bit 1 clear, made while the state is not BUSY, gives a one-cycle eng_start_o pulse in the cycle after the strobe, and the status state field becomes 01. A control write of 0 gives no pulse.
- R5: A control write with bit 1 set gives a one-cycle eng_abort_o pulse. When both bits 0 and 1 are set, the abort takes precedence and no start pulse is issued. If the state was BUSY, the status then reads 0x03.
- R6: Control bits [3:2] set eng_swap_o on every control write and read back at bits [3:2] of the control word. Bits 0 and 1 of the control word read as zero.
- R7: eng_done_i while BUSY returns the state to IDLE and sets status bit 2, so the status reads 0x04 and irq_o is high from the next cycle.
- R8: A status write with bit 2 set clears the done flag, which makes irq_o low and the status read 0x00. A status write with bit 2 clear changes nothing. The state bits cannot be written.
- R9: eng_error_i while BUSY gives status 0x02. eng_aborted_i while BUSY gives status 0x03.
- R10: A start request while BUSY produces no pulse. The done, error and aborted inputs have no effect outside BUSY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_cyc_i | input | 1 | Bus cycle active |
| bus_stb_i | input | 1 | Bus strobe, one access per cycle |
| bus_we_i | input | 1 | Write enable |
| bus_adr_i | input | ADDR_W | Byte address |
| bus_dat_i | input | 32 | Write data |
| bus_ack_o | output | 1 | Acknowledge, one cycle after strobe |
| bus_dat_o | output | 32 | Read data, valid with ack |
| eng_start_o | output | 1 | Start pulse to transfer engine |
| eng_abort_o | output | 1 | Abort pulse to transfer engine |
| eng_swap_o | output | 2 | Byte-swap mode |
| eng_done_i | input | 1 | Engine finished the transfer |
| eng_error_i | input | 1 | Engine hit an error |
| eng_aborted_i | input | 1 | Engine stopped on its own abort |
| host_addr_o | output | 64 | Host start address |
| xfer_bytes_o | output | 32 | Transfer length in bytes |
| next_desc_o | output | 64 | Next-descriptor pointer |
| xfer_attr_o | output | 32 | Attribute word |
| irq_o | output | 1 | Level interrupt, high while done flag set |

## Verification
A wrong state register shows up in the status word on the very next read, because the state field is two bits of it. It also shows as a missing or extra start pulse one cycle after a control write, because GO is refused while BUSY. A wrong done flag shows on irq_o one cycle after the done input or the clearing write, so the bench samples irq_o at that cycle. A decode or read-mux fault shows in the data that comes with the next ack, and the scoreboard compares that data against the value it expects.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    localparam int WORD_W   = 32;
    localparam int SLOT_N   = 9;
    localparam int SLOT_CTL = 0;
    localparam int SLOT_STA = 1;
    localparam int SLOT_GAP = 2;
    localparam int CFG_BASE = 3;
    localparam int CFG_N    = 6;

    // config slot order after CFG_BASE: addr lo, addr hi, bytes, next lo, next hi, attr
    localparam int CFG_ALO  = 0;
    localparam int CFG_AHI  = 1;
    localparam int CFG_LEN  = 2;
    localparam int CFG_NLO  = 3;
    localparam int CFG_NHI  = 4;
    localparam int CFG_ATR  = 5;

    localparam int CTL_GO    = 0;
    localparam int CTL_STOP  = 1;
    localparam int CTL_SWP   = 2;
    localparam int STA_DONE  = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_BUSY    = 2'b01,
        ST_FAULT   = 2'b10,
        ST_ABORTED = 2'b11
    } eng_state_e;

endpackage

// File: rtl/dma_csr_bus.sv
module dma_csr_bus
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           cyc_i,
    input  logic                           stb_i,
    input  logic                           we_i,
    input  logic [ADDR_W-1:0]              adr_i,
    input  logic [WORD_W-1:0]              ctl_rd_i,
    input  logic [WORD_W-1:0]              sta_rd_i,
    input  logic [CFG_N-1:0][WORD_W-1:0]   cfg_rd_i,
    output logic                           ctl_wr_o,
    output logic                           sta_wr_o,
    output logic [CFG_N-1:0]               cfg_wr_o,
    output logic                           ack_o,
    output logic [WORD_W-1:0]              rdat_o
);

    localparam int IDX_W = ADDR_W - 2;

    logic              access;
    logic [IDX_W-1:0]  idx;
    logic              aligned;
    logic              wr_go;
    logic [WORD_W-1:0] rd_sel;

    assign access  = cyc_i && stb_i;
    assign idx     = adr_i[ADDR_W-1:2];
    assign aligned = (adr_i[1:0] == 2'b00);
    assign wr_go   = access && we_i && aligned;

    assign ctl_wr_o = wr_go && (int'(idx) == SLOT_CTL);
    assign sta_wr_o = wr_go && (int'(idx) == SLOT_STA);

    for (genvar g = 0; g < CFG_N; g++) begin : g_cfg_dec
        assign cfg_wr_o[g] = wr_go && (int'(idx) == CFG_BASE + g);
    end

    always_comb begin
        rd_sel = '0;
        if (aligned) begin
            if (int'(idx) == SLOT_CTL) begin
                rd_sel = ctl_rd_i;
            end else if (int'(idx) == SLOT_STA) begin
                rd_sel = sta_rd_i;
            end else begin
                for (int k = 0; k < CFG_N; k++) begin
                    if (int'(idx) == CFG_BASE + k) begin
                        rd_sel = cfg_rd_i[k];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ack_o  <= 1'b0;
            rdat_o <= '0;
        end else begin
            ack_o  <= access;
            rdat_o <= (access && !we_i) ? rd_sel : '0;
        end
    end

    p_ack_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        access |=> ack_o);
    p_no_stray_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !access |=> !ack_o);
    p_gap_reads_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (access && !we_i && int'(idx) == SLOT_GAP) |=> (rdat_o == '0));
    p_one_hot_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({ctl_wr_o, sta_wr_o, cfg_wr_o}));

endmodule

// File: rtl/dma_csr_cfg.sv
module dma_csr_cfg
    import dma_csr_pkg::*;
#(
    parameter int N = CFG_N,
    parameter int W = WORD_W
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [N-1:0]         wr_i,
    input  logic [W-1:0]         wdat_i,
    output logic [N-1:0][W-1:0]  q_o
);

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                q_o[g] <= '0;
            end else if (wr_i[g]) begin
                q_o[g] <= wdat_i;
            end
        end

        p_takes_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wr_i[g] |=> (q_o[g] == $past(wdat_i)));
        p_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !wr_i[g] |=> $stable(q_o[g]));
    end

endmodule

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
    import dma_csr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ctl_wr_i,
    input  logic [3:0]        ctl_bits_i,
    input  logic              sta_wr_i,
    input  logic              clr_bit_i,
    input  logic              done_i,
    input  logic              error_i,
    input  logic              aborted_i,
    output logic              start_o,
    output logic              abort_o,
    output logic [1:0]        swap_o,
    output logic              irq_o,
    output logic [WORD_W-1:0] ctl_rd_o,
    output logic [WORD_W-1:0] sta_rd_o
);

    eng_state_e state_q, state_d;
    logic       start_req;
    logic       abort_req;
    logic       finish;
    logic       done_q;

    assign abort_req = ctl_wr_i && ctl_bits_i[CTL_STOP];
    assign start_req = ctl_wr_i && ctl_bits_i[CTL_GO] && !ctl_bits_i[CTL_STOP]
                       && (state_q != ST_BUSY);

    // next state: GO, FINISH, TRIP, CANCEL
    always_comb begin
        state_d = state_q;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FAULT, ST_ABORTED: begin
                if (start_req) state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (abort_req || aborted_i) begin
                    state_d = ST_ABORTED;
                end else if (error_i) begin
                    state_d = ST_FAULT;
                end else if (done_i) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            start_o <= 1'b0;
            abort_o <= 1'b0;
            swap_o  <= 2'b00;
            done_q  <= 1'b0;
        end else begin
            start_o <= start_req;
            abort_o <= abort_req;
            if (ctl_wr_i) swap_o <= ctl_bits_i[CTL_SWP+1:CTL_SWP];
            if (finish) begin
                done_q <= 1'b1;
            end else if (sta_wr_i && clr_bit_i) begin
                done_q <= 1'b0;
            end
        end
    end

    assign irq_o    = done_q;
    assign ctl_rd_o = {{(WORD_W-4){1'b0}}, swap_o, 2'b00};
    assign sta_rd_o = {{(WORD_W-3){1'b0}}, done_q, state_q};

    p_start_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);
    p_go_enters_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(start_o) |-> (state_q == ST_BUSY));
    p_abort_cancels_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BUSY && abort_req) |=> (state_q == ST_ABORTED));
    p_abort_beats_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |-> !start_o);
    p_irq_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> ($past(done_i) && $past(state_q) == ST_BUSY));
    p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sta_wr_i && clr_bit_i && state_q != ST_BUSY) |=> !irq_o);
    p_no_busy_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BUSY) |=> !start_o);

endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_cyc_i,
    input  logic              bus_stb_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_adr_i,
    input  logic [31:0]       bus_dat_i,
    output logic              bus_ack_o,
    output logic [31:0]       bus_dat_o,
    output logic              eng_start_o,
    output logic              eng_abort_o,
    output logic [1:0]        eng_swap_o,
    input  logic              eng_done_i,
    input  logic              eng_error_i,
    input  logic              eng_aborted_i,
    output logic [63:0]       host_addr_o,
    output logic [31:0]       xfer_bytes_o,
    output logic [63:0]       next_desc_o,
    output logic [31:0]       xfer_attr_o,
    output logic              irq_o
);

    logic                         ctl_wr;
    logic                         sta_wr;
    logic [CFG_N-1:0]             cfg_wr;
    logic [WORD_W-1:0]            ctl_rd;
    logic [WORD_W-1:0]            sta_rd;
    logic [CFG_N-1:0][WORD_W-1:0] cfg_q;

    dma_csr_bus #(.ADDR_W(ADDR_W)) bus_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cyc_i    (bus_cyc_i),
        .stb_i    (bus_stb_i),
        .we_i     (bus_we_i),
        .adr_i    (bus_adr_i),
        .ctl_rd_i (ctl_rd),
        .sta_rd_i (sta_rd),
        .cfg_rd_i (cfg_q),
        .ctl_wr_o (ctl_wr),
        .sta_wr_o (sta_wr),
        .cfg_wr_o (cfg_wr),
        .ack_o    (bus_ack_o),
        .rdat_o   (bus_dat_o)
    );

    dma_csr_cfg #(.N(CFG_N), .W(WORD_W)) cfg_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (cfg_wr),
        .wdat_i (bus_dat_i),
        .q_o    (cfg_q)
    );

    dma_csr_ctrl ctrl_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ctl_wr_i   (ctl_wr),
        .ctl_bits_i (bus_dat_i[3:0]),
        .sta_wr_i   (sta_wr),
        .clr_bit_i  (bus_dat_i[STA_DONE]),
        .done_i     (eng_done_i),
        .error_i    (eng_error_i),
        .aborted_i  (eng_aborted_i),
        .start_o    (eng_start_o),
        .abort_o    (eng_abort_o),
        .swap_o     (eng_swap_o),
        .irq_o      (irq_o),
        .ctl_rd_o   (ctl_rd),
        .sta_rd_o   (sta_rd)
    );

    assign host_addr_o  = {cfg_q[CFG_AHI], cfg_q[CFG_ALO]};
    assign xfer_bytes_o = cfg_q[CFG_LEN];
    assign next_desc_o  = {cfg_q[CFG_NHI], cfg_q[CFG_NLO]};
    assign xfer_attr_o  = cfg_q[CFG_ATR];

endmodule

// File: tb/dma_csr_bank_tb_top.sv
module dma_csr_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [7:0]  adr = '0;
    logic [31:0] wdat = '0;
    logic        ack;
    logic [31:0] rdat;
    logic        start_p, abort_p, irq;
    logic [1:0]  swap;
    logic        done_in = 1'b0, err_in = 1'b0, abt_in = 1'b0;
    logic [63:0] haddr, ndesc;
    logic [31:0] nbytes, attr;

    always #5ns clk = ~clk;

    dma_csr_bank #(.ADDR_W(8)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .bus_cyc_i(cyc), .bus_stb_i(stb), .bus_we_i(we),
        .bus_adr_i(adr), .bus_dat_i(wdat),
        .bus_ack_o(ack), .bus_dat_o(rdat),
        .eng_start_o(start_p), .eng_abort_o(abort_p), .eng_swap_o(swap),
        .eng_done_i(done_in), .eng_error_i(err_in), .eng_aborted_i(abt_in),
        .host_addr_o(haddr), .xfer_bytes_o(nbytes),
        .next_desc_o(ndesc), .xfer_attr_o(attr), .irq_o(irq)
    );

    typedef struct {
        logic [31:0] exp;
        bit          is_rd;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];
    int n_chk  = 0;
    int n_fail = 0;
    logic p1_start, p1_abort, p2_start, p2_abort;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // monitor: every ack pops one expected item
    always @(negedge clk) begin
        if (rst_n && ack) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 ack with nothing pending", 32'd1, 32'd0);
            end else begin
                sb_item_t it;
                it = sb.pop_front();
                if (it.is_rd) check(rdat == it.exp, it.tag, rdat, it.exp);
            end
        end
    end

    // driver tasks: called at a negedge, return at a negedge
    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        sb.push_back('{exp: exp, is_rd: 1'b1, tag: tag});
        cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = a;
        @(negedge clk);
        cyc = 1'b0; stb = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        sb.push_back('{exp: 32'h0, is_rd: 1'b0, tag: "W"});
        cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = a; wdat = d;
        @(negedge clk);
        p1_start = start_p; p1_abort = abort_p;
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        @(negedge clk);
        p2_start = start_p; p2_abort = abort_p;
    endtask

    task automatic pulse_done();
        done_in = 1'b1; @(negedge clk); done_in = 1'b0;
    endtask
    task automatic pulse_err();
        err_in = 1'b1; @(negedge clk); err_in = 1'b0;
    endtask
    task automatic pulse_abt();
        abt_in = 1'b1; @(negedge clk); abt_in = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq == 1'b0, "R1 irq after reset", {31'd0, irq}, 32'd0);
        check(start_p == 1'b0 && abort_p == 1'b0, "R1 pulses after reset",
              {30'd0, start_p, abort_p}, 32'd0);
        check(swap == 2'b00, "R1 swap after reset", {30'd0, swap}, 32'd0);
        for (int a = 0; a <= 32; a += 4) bus_read(8'(a), 32'h0, "R1 reset read");

        // R2 unmapped reads
        bus_read(8'h08, 32'h0, "R2 gap read");
        bus_read(8'h24, 32'h0, "R2 above map read");

        // R3 config readback and outputs
        bus_write(8'h0C, 32'hFFACCE55);
        bus_write(8'h10, 32'h1BADCAFE);
        bus_write(8'h14, 32'h00000080);
        bus_write(8'h18, 32'h20020000);
        bus_write(8'h1C, 32'h00000007);
        bus_write(8'h20, 32'h00000002);
        bus_read(8'h0C, 32'hFFACCE55, "R3 addr lo");
        bus_read(8'h10, 32'h1BADCAFE, "R3 addr hi");
        bus_read(8'h14, 32'h00000080, "R3 bytes");
        bus_read(8'h18, 32'h20020000, "R3 next lo");
        bus_read(8'h1C, 32'h00000007, "R3 next hi");
        bus_read(8'h20, 32'h00000002, "R3 attr");
        check(haddr == 64'h1BADCAFE_FFACCE55, "R3 host_addr_o", haddr[31:0], 32'hFFACCE55);
        check(ndesc == 64'h7_20020000, "R3 next_desc_o", ndesc[63:32], 32'h7);
        check(nbytes == 32'h80 && attr == 32'h2, "R3 bytes/attr out", nbytes, 32'h80);

        // R2 unaligned and gap writes ignored
        bus_write(8'h0E, 32'h12345678);
        bus_write(8'h08, 32'h12345678);
        bus_read(8'h0C, 32'hFFACCE55, "R2 unaligned write ignored");
        bus_read(8'h0D, 32'h0, "R2 unaligned read zero");
        bus_read(8'h08, 32'h0, "R2 gap write ignored");

        // R4 zero control write: no pulse
        bus_write(8'h00, 32'h0);
        check(p1_start == 1'b0 && p1_abort == 1'b0, "R4 zero write no pulse",
              {30'd0, p1_start, p1_abort}, 32'd0);

        // R4 start with swap 3
        bus_write(8'h00, 32'h0D);
        check(p1_start == 1'b1, "R4 start pulse", {31'd0, p1_start}, 32'd1);
        check(p2_start == 1'b0, "R4 start single cycle", {31'd0, p2_start}, 32'd0);
        check(swap == 2'b11, "R6 swap output", {30'd0, swap}, 32'd3);
        bus_read(8'h00, 32'h0C, "R6 control readback");
        bus_read(8'h04, 32'h01, "R4 status busy");

        // R10 restart while busy ignored
        bus_write(8'h00, 32'h0D);
        check(p1_start == 1'b0, "R10 no start while busy", {31'd0, p1_start}, 32'd0);

        // R7 done
        pulse_done();
        check(irq == 1'b1, "R7 irq after done", {31'd0, irq}, 32'd1);
        bus_read(8'h04, 32'h04, "R7 status done");

        // R8 clear semantics
        bus_write(8'h04, 32'hFFFF_FFFB);
        check(irq == 1'b1, "R8 write without bit2 keeps irq", {31'd0, irq}, 32'd1);
        bus_read(8'h04, 32'h04, "R8 state bits read-only");
        bus_write(8'h04, 32'h04);
        check(irq == 1'b0, "R8 irq cleared", {31'd0, irq}, 32'd0);
        bus_read(8'h04, 32'h00, "R8 status cleared");

        // R10 done outside busy ignored
        pulse_done();
        check(irq == 1'b0, "R10 done ignored when idle", {31'd0, irq}, 32'd0);
        bus_read(8'h04, 32'h00, "R10 status after stray done");

        // R5 abort during transfer
        bus_write(8'h00, 32'h01);
        check(swap == 2'b00, "R6 swap rewritten", {30'd0, swap}, 32'd0);
        bus_write(8'h00, 32'h02);
        check(p1_abort == 1'b1 && p2_abort == 1'b0, "R5 abort single pulse",
              {30'd0, p1_abort, p2_abort}, 32'h2);
        bus_read(8'h04, 32'h03, "R5 status aborted");

        // R9 error
        bus_write(8'h00, 32'h01);
        bus_read(8'h04, 32'h01, "R4 restart from aborted");
        pulse_err();
        bus_read(8'h04, 32'h02, "R9 status fault");

        // R9 engine-side abort
        bus_write(8'h00, 32'h01);
        pulse_abt();
        bus_read(8'h04, 32'h03, "R9 status engine aborted");
        check(irq == 1'b0, "R9 no irq on abort", {31'd0, irq}, 32'd0);

        // R10 error outside busy ignored
        pulse_err();
        bus_read(8'h04, 32'h03, "R10 error ignored when not busy");

        // R5 both bits: abort wins
        bus_write(8'h00, 32'h03);
        check(p1_start == 1'b0 && p1_abort == 1'b1, "R5 abort beats start",
              {30'd0, p1_start, p1_abort}, 32'h1);
        bus_read(8'h04, 32'h03, "R5 state unchanged");

        @(negedge clk);
        check(sb.size() == 0, "R2 all accesses acked", sb.size(), 32'd0);
        finish_run();
    end

endmodule